// File: doc/BRIEF.md
# Set-Associative Victim Way Selector

This block decides which way of a four-way set a cache controller should overwrite when a miss forces a line fill. It keeps only replacement state, one record per set, and leaves tags and data to the surrounding cache. A cycle can carry a hit report for a way, a fill into a way, or both. All of them refer to the set on `setIdx`. The valid bits of that set arrive on `lineValid`. The chosen way appears on `victimWay` in the same cycle, with no search sequence.

A parameter fixes the policy at build time. The FIFO variant keeps a one-hot "replace next" marker per set, and each fill moves the marker one way up. The ageing variant keeps a small saturating counter per line. The counter of the touched way clears, and the counters of the other ways in that set count up. The victim is one of the oldest lines. Under both policies an invalid line always wins over a valid one. When several ways qualify equally, a free-running 8-bit LFSR picks the start point of a rotating scan over the candidates. `NUM_WAYS` must be a power of two.

Top module: `way_evict_sel`

## Requirements
- R1: After reset, every set's FIFO marker sits on way 0 and every age counter is zero.
- R2: Whenever at least one bit of `lineValid` is low, `victimWay` names a way whose `lineValid` bit is low, under either policy.
- R3: With several invalid ways, the choice among them comes from an 8-bit LFSR (polynomial x^8+x^6+x^5+x^4+1, nonzero seed) that steps every clock. Over repeated cycles with the same inputs, each invalid way is eventually chosen.
- R4: In FIFO mode with all ways valid, `victimWay` equals the set's marker. A fill (`fillValid` high) moves the marker to the next higher way. A hit report alone leaves the marker unchanged.
- R5: In FIFO mode, a fill while the marker is on the highest way returns the marker to way 0.
- R6: An access or fill changes only the state of the set on `setIdx`. Every other set keeps its marker and its counters.
- R7: In ageing mode, a touch of way w in a set clears w's counter and adds one to every other counter of that set.
- R8: Age counters (AGE_W bits, default 2) stop at their all-ones value and never wrap to zero.
- R9: In ageing mode with all ways valid, the victim holds the largest counter of the set. If several ways share that value, the choice is random among them, and each of them is eventually chosen.
- R10: If a fill and a hit report arrive in the same cycle, the filled way is the touched way. The FIFO marker still advances exactly once.
- R11: `victimWay` depends combinationally on `setIdx`, `lineValid` and the stored state. A change of `setIdx` shows at the output without a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| setIdx | input | $clog2(NUM_SETS) | Set being looked up, hit or filled |
| accValid | input | 1 | A hit occurred in `accWay` of the indexed set |
| accWay | input | $clog2(NUM_WAYS) | Way that hit |
| fillValid | input | 1 | A line is being written into `fillWay` of the indexed set |
| fillWay | input | $clog2(NUM_WAYS) | Way being filled |
| lineValid | input | NUM_WAYS | Valid bits of the indexed set, bit i for way i |
| victimWay | output | $clog2(NUM_WAYS) | Way to replace in the indexed set |

## Verification
The bench drives the FIFO marker across the wrap from the highest way back to way 0. A design that counts past the last way, or that steps the marker on hits, would name the wrong victim. It makes a fill and a hit collide in one cycle, which catches a design that lets the hit win or that advances the marker twice. It walks one counter into saturation and touches the set again, where a wrapping counter would suddenly look youngest and move the victim elsewhere. It holds tied and invalid candidate groups for many cycles, which shows up a tie-break that is fixed or that leaks to a valid or younger way.

// File: rtl/way_evict_pkg.sv
package way_evict_pkg;

  typedef enum logic {
    POL_FIFO = 1'b0,
    POL_AGE  = 1'b1
  } evict_policy_e;

  // Strobes from control to the state datapath
  typedef struct packed {
    logic touch;    // some way of the indexed set was used this cycle
    logic advance;  // a line fill happened this cycle
  } evict_strobe_t;

  localparam int unsigned RND_W = 8;
  localparam logic [RND_W-1:0] RND_SEED = 8'hA5;

endpackage

// File: rtl/way_evict_lfsr.sv
module way_evict_lfsr #(
  parameter int unsigned OUT_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  output logic [OUT_W-1:0] rndBits
);
  import way_evict_pkg::*;

  logic [RND_W-1:0] shiftQ;
  logic             feedback;

  // x^8 + x^6 + x^5 + x^4 + 1, maximal length
  assign feedback = shiftQ[7] ^ shiftQ[5] ^ shiftQ[4] ^ shiftQ[3];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shiftQ <= RND_SEED;
    else       shiftQ <= {shiftQ[RND_W-2:0], feedback};
  end

  assign rndBits = shiftQ[OUT_W-1:0];

  // R3: the random source must never lock up in the all-zero state
  a_r3_lfsr_alive: assert property (@(posedge clk) disable iff (!rstN)
    shiftQ != '0) else $error("a_r3_lfsr_alive");

endmodule

// File: rtl/way_evict_pick.sv
module way_evict_pick #(
  parameter int unsigned NUM_WAYS = 4,
  localparam int unsigned WAY_W = $clog2(NUM_WAYS)
) (
  input  logic [NUM_WAYS-1:0] cand,
  input  logic [WAY_W-1:0]    startWay,
  output logic [WAY_W-1:0]    pickWay
);
  // Rotating priority scan starting at startWay; one pass, no iteration in time
  always_comb begin
    logic             found;
    logic [WAY_W-1:0] probe;
    found   = 1'b0;
    pickWay = '0;
    for (int k = 0; k < NUM_WAYS; k++) begin
      probe = startWay + WAY_W'(k);
      if (!found && cand[probe]) begin
        pickWay = probe;
        found   = 1'b1;
      end
    end
  end

endmodule

// File: rtl/way_evict_ctrl.sv
module way_evict_ctrl #(
  parameter int unsigned NUM_WAYS = 4,
  localparam int unsigned WAY_W = $clog2(NUM_WAYS)
) (
  input  logic                          accValid,
  input  logic [WAY_W-1:0]              accWay,
  input  logic                          fillValid,
  input  logic [WAY_W-1:0]              fillWay,
  output way_evict_pkg::evict_strobe_t  strobe,
  output logic [WAY_W-1:0]              touchWay
);
  // A fill outranks a simultaneous hit report
  always_comb begin
    strobe.touch   = accValid | fillValid;
    strobe.advance = fillValid;
    touchWay       = fillValid ? fillWay : accWay;
  end

endmodule

// File: rtl/way_evict_dp.sv
module way_evict_dp #(
  parameter int unsigned NUM_SETS = 8,
  parameter int unsigned NUM_WAYS = 4,
  parameter int unsigned AGE_W    = 2,
  parameter way_evict_pkg::evict_policy_e POLICY = way_evict_pkg::POL_FIFO,
  localparam int unsigned WAY_W = $clog2(NUM_WAYS),
  localparam int unsigned SET_W = $clog2(NUM_SETS)
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [SET_W-1:0]             setIdx,
  input  way_evict_pkg::evict_strobe_t strobe,
  input  logic [WAY_W-1:0]             touchWay,
  input  logic [NUM_WAYS-1:0]          lineValid,
  input  logic [WAY_W-1:0]             rndStart,
  output logic [WAY_W-1:0]             victimWay
);
  import way_evict_pkg::*;

  localparam logic [AGE_W-1:0] AGE_MAX = {AGE_W{1'b1}};

  logic [NUM_WAYS-1:0] invMask;
  logic                anyInvalid;
  logic [NUM_WAYS-1:0] policyCand;
  logic [NUM_WAYS-1:0] cand;

  function automatic logic [NUM_WAYS-1:0] rotUp(input logic [NUM_WAYS-1:0] m);
    return {m[NUM_WAYS-2:0], m[NUM_WAYS-1]};
  endfunction

  generate
    if (POLICY == POL_FIFO) begin : g_fifo
      logic [NUM_WAYS-1:0] markerQ [NUM_SETS];

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          for (int s = 0; s < NUM_SETS; s++) markerQ[s] <= NUM_WAYS'(1);
        end else if (strobe.advance) begin
          markerQ[setIdx] <= rotUp(markerQ[setIdx]);
        end
      end

      always_comb policyCand = markerQ[setIdx];

      // R4: with a full set the controller fills the way presented as victim
      a_r4_fill_at_marker: assert property (@(posedge clk) disable iff (!rstN)
        (strobe.advance && (&lineValid)) |-> markerQ[setIdx][touchWay])
        else $error("a_r4_fill_at_marker");

      for (genvar gs = 0; gs < NUM_SETS; gs++) begin : g_set
        a_r4_marker_onehot: assert property (@(posedge clk) disable iff (!rstN)
          $countones(markerQ[gs]) == 1) else $error("a_r4_marker_onehot");

        // R5: step up by one way, wrapping from the top way to way 0
        a_r5_marker_step: assert property (@(posedge clk) disable iff (!rstN)
          (strobe.advance && setIdx == SET_W'(gs)) |=> markerQ[gs] == rotUp($past(markerQ[gs])))
          else $error("a_r5_marker_step");

        a_r6_marker_hold: assert property (@(posedge clk) disable iff (!rstN)
          !(strobe.advance && setIdx == SET_W'(gs)) |=> $stable(markerQ[gs]))
          else $error("a_r6_marker_hold");

        a_r4_hit_no_move: assert property (@(posedge clk) disable iff (!rstN)
          (strobe.touch && !strobe.advance) |=> $stable(markerQ[gs]))
          else $error("a_r4_hit_no_move");
      end
    end else begin : g_age
      logic [AGE_W-1:0] ageQ [NUM_SETS][NUM_WAYS];
      logic [AGE_W-1:0] maxAge;

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          for (int s = 0; s < NUM_SETS; s++)
            for (int w = 0; w < NUM_WAYS; w++) ageQ[s][w] <= '0;
        end else if (strobe.touch) begin
          for (int w = 0; w < NUM_WAYS; w++) begin
            if (WAY_W'(w) == touchWay)
              ageQ[setIdx][w] <= '0;
            else if (ageQ[setIdx][w] != AGE_MAX)
              ageQ[setIdx][w] <= ageQ[setIdx][w] + 1'b1;
          end
        end
      end

      always_comb begin
        maxAge = '0;
        for (int w = 0; w < NUM_WAYS; w++)
          if (ageQ[setIdx][w] > maxAge) maxAge = ageQ[setIdx][w];
        for (int w = 0; w < NUM_WAYS; w++)
          policyCand[w] = (ageQ[setIdx][w] == maxAge);
      end

      for (genvar gs = 0; gs < NUM_SETS; gs++) begin : g_set
        for (genvar gw = 0; gw < NUM_WAYS; gw++) begin : g_way
          a_r7_age_clear: assert property (@(posedge clk) disable iff (!rstN)
            (strobe.touch && setIdx == SET_W'(gs) && touchWay == WAY_W'(gw)) |=> ageQ[gs][gw] == '0)
            else $error("a_r7_age_clear");

          a_r8_age_saturate: assert property (@(posedge clk) disable iff (!rstN)
            (strobe.touch && setIdx == SET_W'(gs) && touchWay != WAY_W'(gw) && ageQ[gs][gw] == AGE_MAX)
            |=> ageQ[gs][gw] == AGE_MAX) else $error("a_r8_age_saturate");

          a_r6_age_other_set: assert property (@(posedge clk) disable iff (!rstN)
            !(strobe.touch && setIdx == SET_W'(gs)) |=> $stable(ageQ[gs][gw]))
            else $error("a_r6_age_other_set");

          a_r10_fill_clears: assert property (@(posedge clk) disable iff (!rstN)
            (strobe.advance && setIdx == SET_W'(gs) && touchWay == WAY_W'(gw)) |=> ageQ[gs][gw] == '0)
            else $error("a_r10_fill_clears");
        end
      end
    end
  endgenerate

  assign invMask    = ~lineValid;
  assign anyInvalid = |invMask;
  assign cand       = anyInvalid ? invMask : policyCand;

  way_evict_pick #(.NUM_WAYS(NUM_WAYS)) u_pick (
    .cand     (cand),
    .startWay (rndStart),
    .pickWay  (victimWay)
  );

endmodule

// File: rtl/way_evict_sel.sv
module way_evict_sel #(
  parameter int unsigned NUM_SETS = 8,
  parameter int unsigned NUM_WAYS = 4,
  parameter int unsigned AGE_W    = 2,
  parameter way_evict_pkg::evict_policy_e POLICY = way_evict_pkg::POL_FIFO,
  localparam int unsigned WAY_W = $clog2(NUM_WAYS),
  localparam int unsigned SET_W = $clog2(NUM_SETS)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [SET_W-1:0]    setIdx,
  input  logic                accValid,
  input  logic [WAY_W-1:0]    accWay,
  input  logic                fillValid,
  input  logic [WAY_W-1:0]    fillWay,
  input  logic [NUM_WAYS-1:0] lineValid,
  output logic [WAY_W-1:0]    victimWay
);
  import way_evict_pkg::*;

  evict_strobe_t    strobe;
  logic [WAY_W-1:0] touchWay;
  logic [WAY_W-1:0] rndStart;

  way_evict_ctrl #(.NUM_WAYS(NUM_WAYS)) u_ctrl (
    .accValid  (accValid),
    .accWay    (accWay),
    .fillValid (fillValid),
    .fillWay   (fillWay),
    .strobe    (strobe),
    .touchWay  (touchWay)
  );

  way_evict_lfsr #(.OUT_W(WAY_W)) u_lfsr (
    .clk     (clk),
    .rstN    (rstN),
    .rndBits (rndStart)
  );

  way_evict_dp #(
    .NUM_SETS (NUM_SETS),
    .NUM_WAYS (NUM_WAYS),
    .AGE_W    (AGE_W),
    .POLICY   (POLICY)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .setIdx    (setIdx),
    .strobe    (strobe),
    .touchWay  (touchWay),
    .lineValid (lineValid),
    .rndStart  (rndStart),
    .victimWay (victimWay)
  );

  // R2: an empty line is always used before any valid one
  a_r2_invalid_first: assert property (@(posedge clk) disable iff (!rstN)
    (|(~lineValid)) |-> !lineValid[victimWay]) else $error("a_r2_invalid_first");

endmodule

// File: tb/way_evict_sel_bench.sv
module way_evict_sel_bench;
  import way_evict_pkg::*;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  // FIFO instance stimulus
  logic [2:0] fSet = '0;
  logic       fAcc = 1'b0, fFill = 1'b0;
  logic [1:0] fAccWay = '0, fFillWay = '0;
  logic [3:0] fValid = 4'hF;
  logic [1:0] fVictim;
  // Ageing instance stimulus
  logic [2:0] lSet = '0;
  logic       lAcc = 1'b0, lFill = 1'b0;
  logic [1:0] lAccWay = '0, lFillWay = '0;
  logic [3:0] lValid = 4'hF;
  logic [1:0] lVictim;

  int checks = 0;
  int failures = 0;

  way_evict_sel #(.POLICY(POL_FIFO)) u_way_evict_sel (
    .clk(clk), .rstN(rstN), .setIdx(fSet), .accValid(fAcc), .accWay(fAccWay),
    .fillValid(fFill), .fillWay(fFillWay), .lineValid(fValid), .victimWay(fVictim));

  way_evict_sel #(.POLICY(POL_AGE)) u_way_evict_sel_age (
    .clk(clk), .rstN(rstN), .setIdx(lSet), .accValid(lAcc), .accWay(lAccWay),
    .fillValid(lFill), .fillWay(lFillWay), .lineValid(lValid), .victimWay(lVictim));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Watch one instance for n cycles: every pick inside allowed, and all of allowed seen
  task automatic checkSpread(input string req, input bit age, input logic [3:0] allowed, input int n);
    logic [3:0] seen;
    bit         stray;
    int         bad;
    seen = '0; stray = 1'b0; bad = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
      if (age) begin seen[lVictim] = 1'b1; if (!allowed[lVictim]) begin stray = 1'b1; bad = lVictim; end end
      else     begin seen[fVictim] = 1'b1; if (!allowed[fVictim]) begin stray = 1'b1; bad = fVictim; end end
    end
    checks++;
    if (stray) begin failures++; $display("FAIL %s outside candidates actual=%0d expected_mask=%b", req, bad, allowed); end
    checks++;
    if (seen != allowed) begin failures++; $display("FAIL %s coverage actual_seen=%b expected=%b", req, seen, allowed); end
  endtask

  task automatic fifoStep(input int s, input bit fill, input int fw, input bit hit, input int hw);
    @(negedge clk);
    fSet = 3'(s); fFill = fill; fFillWay = 2'(fw); fAcc = hit; fAccWay = 2'(hw);
    @(negedge clk);
    fFill = 1'b0; fAcc = 1'b0; #1;
  endtask

  task automatic ageStep(input int s, input bit fill, input int fw, input bit hit, input int hw);
    @(negedge clk);
    lSet = 3'(s); lFill = fill; lFillWay = 2'(fw); lAcc = hit; lAccWay = 2'(hw);
    @(negedge clk);
    lFill = 1'b0; lAcc = 1'b0; #1;
  endtask

  task automatic testReset();
    @(negedge clk); fSet = 3'd2; #1;
    check("R1 fifo marker set2 after reset", int'(fVictim), 0);
    fSet = 3'd5; #1;
    check("R1 fifo marker set5 after reset", int'(fVictim), 0);
  endtask

  task automatic testFifoOrder();
    fifoStep(2, 1, 0, 0, 0); check("R4 fill advances 0->1", int'(fVictim), 1);
    fifoStep(2, 1, 1, 0, 0); check("R4 fill advances 1->2", int'(fVictim), 2);
    fifoStep(2, 0, 0, 1, 1); check("R4 hit leaves marker", int'(fVictim), 2);
    fifoStep(2, 1, 2, 0, 0); check("R4 fill advances 2->3", int'(fVictim), 3);
  endtask

  task automatic testFifoWrap();
    fifoStep(2, 1, 3, 0, 0); check("R5 wrap 3->0", int'(fVictim), 0);
    fifoStep(2, 1, 0, 0, 0); check("R5 after wrap 0->1", int'(fVictim), 1);
  endtask

  task automatic testSetsAndComb();
    @(negedge clk); fSet = 3'd5; #1;
    check("R6 set5 untouched by set2 fills", int'(fVictim), 0);
    check("R11 set switch visible without edge (set5)", int'(fVictim), 0);
    fSet = 3'd2; #1;
    check("R11 set switch visible without edge (set2)", int'(fVictim), 1);
  endtask

  task automatic testFifoCollide();
    fifoStep(2, 1, 1, 1, 3);
    check("R10 fifo fill+hit advances once", int'(fVictim), 2);
  endtask

  task automatic testFifoInvalid();
    @(negedge clk); fSet = 3'd2; fValid = 4'b1110;
    checkSpread("R2 fifo single invalid way0", 1'b0, 4'b0001, 8);
    @(negedge clk); fValid = 4'b0101;
    checkSpread("R3 random among invalid ways 1,3", 1'b0, 4'b1010, 64);
    @(negedge clk); fValid = 4'hF; #1;
    check("R4 marker back in control when full", int'(fVictim), 2);
  endtask

  task automatic testAgeing();
    ageStep(1, 0, 0, 1, 0);
    ageStep(1, 0, 0, 1, 1);
    ageStep(1, 0, 0, 1, 2);  // ages 2,1,0,3
    check("R7 R9 oldest way after touches", int'(lVictim), 3);
  endtask

  task automatic testAgeSaturate();
    ageStep(1, 0, 0, 1, 0);  // ages 0,2,1,3 (way3 held at max)
    check("R8 saturated way stays oldest", int'(lVictim), 3);
    ageStep(1, 0, 0, 1, 0);  // ages 0,3,2,3
    checkSpread("R9 tie between ways 1 and 3", 1'b1, 4'b1010, 64);
  endtask

  task automatic testAgeOtherSet();
    ageStep(6, 0, 0, 1, 3);  // set6 ages 1,1,1,0
    checkSpread("R6 set6 tie excludes touched way3", 1'b1, 4'b0111, 64);
    @(negedge clk); lSet = 3'd1;
    checkSpread("R6 set1 unchanged by set6 touch", 1'b1, 4'b1010, 32);
  endtask

  task automatic testAgeCollide();
    ageStep(4, 0, 0, 1, 0);  // 0,1,1,1
    ageStep(4, 0, 0, 1, 1);  // 1,0,2,2
    ageStep(4, 1, 3, 1, 2);  // fill way3 wins: 2,1,3,0
    check("R10 fill outranks hit in ageing mode", int'(lVictim), 2);
    @(negedge clk); lSet = 3'd1; #1;
    lSet = 3'd4; #1;
    check("R11 ageing victim follows set without edge", int'(lVictim), 2);
  endtask

  task automatic testAgeInvalid();
    @(negedge clk); lSet = 3'd1; lValid = 4'b1011;
    checkSpread("R2 ageing invalid way2 beats older ways", 1'b1, 4'b0100, 8);
    @(negedge clk); lValid = 4'hF;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testFifoOrder();
    testFifoWrap();
    testSetsAndComb();
    testFifoCollide();
    testFifoInvalid();
    testAgeing();
    testAgeSaturate();
    testAgeOtherSet();
    testAgeCollide();
    testAgeInvalid();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule